// File: doc/BRIEF.md
# Disk Channel Adapter Register File

This block is the host-facing register set of a bus adapter that sits between a system bus and a disk channel. A host issues longword reads and writes into eight 32-bit registers: configuration, control, status, transfer virtual address, transfer byte count, diagnostic, selected map entry and command address. The last two only pass values in from the surrounding adapter logic. The block keeps the status word, including the transfer-busy flag, the completion, abort and error flags, and attention. It reports status to the host through a single level-sensitive interrupt request.

The drive side pulses `xfer_start` when it launches a data transfer. The transfer engine reports the end of a transfer on `xfer_done`, or a fault on `xfer_fault`. Drives raise or drop attention, and can flag an exception. While a transfer is busy, the interrupt request is held back. The host cannot alter the address or count registers under a running transfer; such a write is refused and recorded as a programming error. Writing the init bit of the control register returns the whole adapter to its reset state.

Top module: `dchan_regfile`

## Requirements
- R1: After reset, status, control, virtual address, byte count and diagnostic read 0x00000000, configuration reads 0x00400000 ORed with the adapter code in bits 7:0 (code 0x20 by default), and `irq` is low.
- R2: An access is valid only when `host_size` is 2'b10 (longword) and `host_addr[1:0]` is 0. Any other access raises `host_err` in the same cycle, returns 0 on `host_rdata` and changes no register.
- R3: Register offsets are byte addresses 0,4,...,28, in this order: configuration, control, status, virtual address, byte count, diagnostic, selected map, command. Control keeps only bits 3:1 (abort, interrupt enable in bit 2, maintenance), and all other bits read 0. Writing bit 0 of control resets every register and `irq` as in R1, then stores bits 3:1 of the same write.
- R4: Configuration bits 22 and 23 clear when written with 1. Bits 7:0 always read the adapter code. Writes have no other effect on the register.
- R5: The virtual address register keeps bits 16:0 and the byte count register keeps bits 15:0, with upper bits reading 0. The diagnostic register keeps bits 31:22, and its bits 21:0 read 0.
- R6: A write to virtual address or byte count while busy (status bit 31) leaves that register unchanged and sets the programming-error flag, status bit 19.
- R7: A pulse on `xfer_start` while not busy sets bit 31 and clears every status bit under mask 0x608E79FF. A pulse while busy sets bit 19 and leaves bit 31 set.
- R8: `xfer_done` sets bit 13. An abort-class event (`xfer_fault`, or a control write with bit 1 set while busy) sets bits 12 and 13. Setting bit 12 or 13 clears bit 31.
- R9: `attn_set` sets status bit 16 and `attn_clr` clears it, with set winning if both are pulsed. `exc_event` sets bit 7.
- R10: Writing status clears the bits under mask 0x608E79FF where the data holds 1. Bits 31 and 16 are not affected by the write, and reserved bits read 0. Offsets 24 and 28 read `smap_in` and `cmd_in` and ignore writes.
- R11: `irq` rises one clock after an update that sets a status bit under mask 0x000F7000, provided control bit 2 is 1 and bit 31 is 0 after that update.
- R12: An event that sets an interrupt-class bit while bit 31 stays set does not raise `irq`.
- R13: Once raised, `irq` stays high until no status bit under 0x000F7000 remains set, or control bit 2 is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | Host access valid this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | Access size: 2'b10 longword, 2'b01 word, 2'b00 byte |
| host_addr | input | 5 | Byte address within the register window |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational, valid while a read is presented |
| host_err | output | 1 | Access rejected: wrong size or misaligned |
| xfer_start | input | 1 | Drive side launches a data transfer (pulse) |
| xfer_done | input | 1 | Transfer completed (pulse) |
| xfer_fault | input | 1 | Abort-class transfer failure (pulse) |
| attn_set | input | 1 | Drive raises attention (pulse) |
| attn_clr | input | 1 | Drive drops attention (pulse) |
| exc_event | input | 1 | Channel exception (pulse) |
| smap_in | input | 32 | Value returned for the selected-map register |
| cmd_in | input | 32 | Value returned for the command-address register |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions check the following on every cycle: a rejected access leaves the address and count registers untouched, a refused write under busy flags a programming error, a second start flags the error, completion is never seen alongside busy, and `irq` can only rise with interrupts enabled and busy clear and never stays high without a cause bit. Only the bench's scenarios can show the exact register values. These include the write masks and write-one-to-clear effects, the deferral of an attention raised during a transfer until completion, the abort path through the control register, and the full return to reset values after an init write.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
  localparam int unsigned REG_CNT = 8;
  localparam int unsigned OFS_W   = $clog2(REG_CNT);
  localparam int unsigned HADDR_W = OFS_W + 2;

  typedef enum logic [2:0] {
    RG_CFG   = 3'd0,
    RG_CTL   = 3'd1,
    RG_STS   = 3'd2,
    RG_VADDR = 3'd3,
    RG_BCNT  = 3'd4,
    RG_DIAG  = 3'd5,
    RG_SMAP  = 3'd6,
    RG_CMD   = 3'd7
  } reg_sel_e;

  localparam logic [1:0] SZ_LONG = 2'b10;

  // status bit positions
  localparam int unsigned ST_EXC  = 7;
  localparam int unsigned ST_ABT  = 12;
  localparam int unsigned ST_CMP  = 13;
  localparam int unsigned ST_ATN  = 16;
  localparam int unsigned ST_PGE  = 19;
  localparam int unsigned ST_BUSY = 31;

  localparam logic [31:0] ST_ERR_MASK  = 32'h608E_49FF;
  localparam logic [31:0] ST_DONE_MASK = (32'h1 << ST_ABT) | (32'h1 << ST_CMP);
  localparam logic [31:0] ST_W1C_MASK  = ST_ERR_MASK | ST_DONE_MASK;
  localparam logic [31:0] ST_IRQ_MASK  = 32'h000F_7000;
  localparam logic [31:0] ST_KEEP_MASK = ST_W1C_MASK | (32'h1 << ST_ATN) | (32'h1 << ST_BUSY);

  // control bit positions
  localparam int unsigned CT_INIT  = 0;
  localparam int unsigned CT_ABORT = 1;
  localparam int unsigned CT_IE    = 2;

  // configuration bit positions
  localparam int unsigned CF_PU = 22;
  localparam int unsigned CF_PD = 23;

  // diagnostic writable field starts here
  localparam int unsigned DG_LO = 22;
endpackage

// File: rtl/dchan_host_decode.sv
module dchan_host_decode
  import dchan_pkg::*;
(
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic [1:0]           host_size,
  input  logic [HADDR_W-1:0]   host_addr,
  output logic                 acc_ok,
  output logic                 acc_fault,
  output logic [REG_CNT-1:0]   wr_sel,
  output logic [OFS_W-1:0]     rd_ofs
);
  logic shape_ok;

  assign shape_ok  = (host_size == SZ_LONG) && (host_addr[1:0] == 2'b00);
  assign acc_ok    = host_req & shape_ok;
  assign acc_fault = host_req & ~shape_ok;
  assign rd_ofs    = host_addr[HADDR_W-1:2];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_wsel
    assign wr_sel[g] = acc_ok & host_we & (host_addr[HADDR_W-1:2] == OFS_W'(g));
  end
endmodule

// File: rtl/dchan_status_unit.sv
module dchan_status_unit
  import dchan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_clr,
  input  logic        start,
  input  logic        done,
  input  logic        fault,
  input  logic        attn_set,
  input  logic        attn_clr,
  input  logic        exc,
  input  logic        host_pge,
  input  logic        host_abort,
  input  logic        host_w1c_we,
  input  logic [31:0] host_wdata,
  output logic [31:0] sr_q,
  output logic [31:0] sr_nx,
  output logic [31:0] set_v
);
  logic        busy;
  logic        start_ok;
  logic [31:0] base;
  logic        sr_en;

  assign busy     = sr_q[ST_BUSY];
  assign start_ok = start & ~busy;

  always_comb begin
    set_v = '0;
    if (start & busy)        set_v[ST_PGE] = 1'b1;
    if (host_pge)            set_v[ST_PGE] = 1'b1;
    if (done)                set_v[ST_CMP] = 1'b1;
    if (fault | host_abort) begin
      set_v[ST_CMP] = 1'b1;
      set_v[ST_ABT] = 1'b1;
    end
    if (attn_set)            set_v[ST_ATN] = 1'b1;
    if (exc)                 set_v[ST_EXC] = 1'b1;
    if (init_clr)            set_v = '0;
  end

  always_comb begin
    base = sr_q;
    if (host_w1c_we) base = base & ~(host_wdata & ST_W1C_MASK);
    if (start_ok)    base = (base & ~ST_W1C_MASK) | (32'h1 << ST_BUSY);
    sr_nx = base | set_v;
    if (attn_clr & ~attn_set)            sr_nx[ST_ATN]  = 1'b0;
    if (|(set_v & ST_DONE_MASK))         sr_nx[ST_BUSY] = 1'b0;
    sr_nx = sr_nx & ST_KEEP_MASK;
    if (init_clr) sr_nx = '0;
  end

  assign sr_en = (sr_nx != sr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_nx;
  end
endmodule

// File: rtl/dchan_irq_unit.sv
module dchan_irq_unit
  import dchan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_clr,
  input  logic        ie_nx,
  input  logic [31:0] set_v,
  input  logic [31:0] sr_nx,
  output logic        irq_q
);
  logic raise;
  logic hold;
  logic irq_nx;

  assign raise  = (|(set_v & ST_IRQ_MASK)) & ie_nx & ~sr_nx[ST_BUSY];
  assign hold   = irq_q & ie_nx & (|(sr_nx & ST_IRQ_MASK));
  assign irq_nx = ~init_clr & (raise | hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nx;
  end
endmodule

// File: rtl/dchan_regfile.sv
module dchan_regfile
  import dchan_pkg::*;
#(
  parameter logic [7:0] ADAPTER_CODE = 8'h20,
  parameter int unsigned VA_W = 17,
  parameter int unsigned BC_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_req,
  input  logic                host_we,
  input  logic [1:0]          host_size,
  input  logic [HADDR_W-1:0]  host_addr,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  output logic                host_err,
  input  logic                xfer_start,
  input  logic                xfer_done,
  input  logic                xfer_fault,
  input  logic                attn_set,
  input  logic                attn_clr,
  input  logic                exc_event,
  input  logic [31:0]         smap_in,
  input  logic [31:0]         cmd_in,
  output logic                irq
);
  localparam int unsigned DG_W = 32 - DG_LO;

  // reset release synchronizer
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic               acc_ok;
  logic [REG_CNT-1:0] wr_sel;
  logic [OFS_W-1:0]   rd_ofs;

  dchan_host_decode u_dec (
    .host_req  (host_req),
    .host_we   (host_we),
    .host_size (host_size),
    .host_addr (host_addr),
    .acc_ok    (acc_ok),
    .acc_fault (host_err),
    .wr_sel    (wr_sel),
    .rd_ofs    (rd_ofs)
  );

  logic [31:0] sr_q;
  logic [31:0] sr_nx;
  logic [31:0] set_v;
  logic        busy;
  logic        init_clr;
  logic        host_pge;
  logic        host_abort;

  assign busy       = sr_q[ST_BUSY];
  assign init_clr   = wr_sel[RG_CTL] & host_wdata[CT_INIT];
  assign host_pge   = (wr_sel[RG_VADDR] | wr_sel[RG_BCNT]) & busy;
  assign host_abort = wr_sel[RG_CTL] & host_wdata[CT_ABORT] & busy;

  // control: bits 3:1 kept
  logic [3:1] ctl_q, ctl_nx;
  logic       ctl_en;

  assign ctl_en = wr_sel[RG_CTL];
  assign ctl_nx = ctl_en ? host_wdata[3:1] : ctl_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctl_q <= '0;
    else if (ctl_en)  ctl_q <= ctl_nx;
  end

  // configuration: power-up / power-down flags
  logic [1:0] cfg_q, cfg_nx;
  logic       cfg_en;

  always_comb begin
    cfg_nx = cfg_q;
    if (wr_sel[RG_CFG]) cfg_nx = cfg_q & ~host_wdata[CF_PD:CF_PU];
    if (init_clr)       cfg_nx = 2'b01;
  end
  assign cfg_en = wr_sel[RG_CFG] | init_clr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= 2'b01;
    else if (cfg_en) cfg_q <= cfg_nx;
  end

  // virtual address and byte count: refused while busy
  logic [VA_W-1:0] va_q, va_nx;
  logic [BC_W-1:0] bc_q, bc_nx;
  logic            va_en, bc_en;

  assign va_en = init_clr | (wr_sel[RG_VADDR] & ~busy);
  assign bc_en = init_clr | (wr_sel[RG_BCNT] & ~busy);
  assign va_nx = init_clr ? '0 : host_wdata[VA_W-1:0];
  assign bc_nx = init_clr ? '0 : host_wdata[BC_W-1:0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) va_q <= '0;
    else if (va_en)  va_q <= va_nx;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bc_q <= '0;
    else if (bc_en)  bc_q <= bc_nx;
  end

  // diagnostic upper field
  logic [DG_W-1:0] dg_q, dg_nx;
  logic            dg_en;

  assign dg_en = init_clr | wr_sel[RG_DIAG];
  assign dg_nx = init_clr ? '0 : host_wdata[31:DG_LO];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dg_q <= '0;
    else if (dg_en)  dg_q <= dg_nx;
  end

  dchan_status_unit u_sts (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .init_clr    (init_clr),
    .start       (xfer_start),
    .done        (xfer_done),
    .fault       (xfer_fault),
    .attn_set    (attn_set),
    .attn_clr    (attn_clr),
    .exc         (exc_event),
    .host_pge    (host_pge),
    .host_abort  (host_abort),
    .host_w1c_we (wr_sel[RG_STS]),
    .host_wdata  (host_wdata),
    .sr_q        (sr_q),
    .sr_nx       (sr_nx),
    .set_v       (set_v)
  );

  dchan_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .init_clr (init_clr),
    .ie_nx    (ctl_nx[CT_IE]),
    .set_v    (set_v),
    .sr_nx    (sr_nx),
    .irq_q    (irq)
  );

  // read path
  logic [31:0] rd_mux;

  always_comb begin
    case (reg_sel_e'(rd_ofs))
      RG_CFG:   rd_mux = {8'h00, cfg_q, 14'h0000, ADAPTER_CODE};
      RG_CTL:   rd_mux = {28'h0000000, ctl_q, 1'b0};
      RG_STS:   rd_mux = sr_q;
      RG_VADDR: rd_mux = 32'(va_q);
      RG_BCNT:  rd_mux = 32'(bc_q);
      RG_DIAG:  rd_mux = {dg_q, {DG_LO{1'b0}}};
      RG_SMAP:  rd_mux = smap_in;
      RG_CMD:   rd_mux = cmd_in;
      default:  rd_mux = '0;
    endcase
  end

  assign host_rdata = (acc_ok & ~host_we) ? rd_mux : 32'h0;
endmodule

// File: rtl/dchan_regfile_chk.sv
module dchan_regfile_chk
  import dchan_pkg::*;
#(
  parameter int unsigned VA_W = 17,
  parameter int unsigned BC_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_req,
  input logic               host_we,
  input logic [1:0]         host_size,
  input logic [HADDR_W-1:0] host_addr,
  input logic [31:0]        host_wdata,
  input logic               host_err,
  input logic               xfer_start,
  input logic               attn_set,
  input logic [31:0]        sr,
  input logic [VA_W-1:0]    va,
  input logic [BC_W-1:0]    bc,
  input logic [3:1]         ctl,
  input logic               irq
);
  logic good_acc, bad_acc, init_wr, va_wr;

  assign good_acc = host_req && (host_size == SZ_LONG) && (host_addr[1:0] == 2'b00);
  assign bad_acc  = host_req && !((host_size == SZ_LONG) && (host_addr[1:0] == 2'b00));
  assign init_wr  = good_acc && host_we && (host_addr[HADDR_W-1:2] == OFS_W'(RG_CTL)) && host_wdata[CT_INIT];
  assign va_wr    = good_acc && host_we && (host_addr[HADDR_W-1:2] == OFS_W'(RG_VADDR));

  assert_fault_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |-> host_err);

  assert_fault_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> ($stable(va) && $stable(bc)));

  assert_busy_refuse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (va_wr && sr[ST_BUSY]) |=> ($stable(va) && sr[ST_PGE]));

  assert_restart_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && sr[ST_BUSY] && !init_wr) |=> sr[ST_PGE]);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[ST_CMP]) |-> !sr[ST_BUSY]);

  assert_attn_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_set && !init_wr) |=> sr[ST_ATN]);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (ctl[CT_IE] && !sr[ST_BUSY]));

  assert_irq_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(sr & ST_IRQ_MASK)));
endmodule

bind dchan_regfile dchan_regfile_chk #(.VA_W(VA_W), .BC_W(BC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_req   (host_req),
  .host_we    (host_we),
  .host_size  (host_size),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_err   (host_err),
  .xfer_start (xfer_start),
  .attn_set   (attn_set),
  .sr         (sr_q),
  .va         (va_q),
  .bc         (bc_q),
  .ctl        (ctl_q),
  .irq        (irq)
);

// File: tb/test_dchan_regfile.sv
module test_dchan_regfile;
  import dchan_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [1:0]  host_size = SZ_LONG;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_err;
  logic        xfer_start = 1'b0, xfer_done = 1'b0, xfer_fault = 1'b0;
  logic        attn_set = 1'b0, attn_clr = 1'b0, exc_event = 1'b0;
  logic [31:0] smap_in = 32'hA5A5_0F0F;
  logic [31:0] cmd_in  = 32'h1234_5678;
  logic        irq;

  always #4 clk = ~clk; // 125 MHz

  dchan_regfile i_dchan_regfile (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_size(host_size), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_err(host_err), .xfer_start(xfer_start),
    .xfer_done(xfer_done), .xfer_fault(xfer_fault), .attn_set(attn_set),
    .attn_clr(attn_clr), .exc_event(exc_event), .smap_in(smap_in),
    .cmd_in(cmd_in), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EV = 2'd2, K_IRQ = 2'd3;
  localparam logic [31:0] EV_START = 32'd1, EV_DONE = 32'd2, EV_FAULT = 32'd4,
                          EV_ASET = 32'd8, EV_ACLR = 32'd16, EV_EXC = 32'd32;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 55;
  localparam vec_t TBL [NV] = '{
    '{K_RD,  5'd0,  32'h0, 32'h0040_0020, 4'd1},  // R1 config reset
    '{K_RD,  5'd8,  32'h0, 32'h0000_0000, 4'd1},  // R1 status reset
    '{K_RD,  5'd4,  32'h0, 32'h0000_0000, 4'd1},  // R1 control reset
    '{K_RD,  5'd12, 32'h0, 32'h0000_0000, 4'd1},  // R1 address reset
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0000, 4'd1},  // R1 irq low
    '{K_WR,  5'd4,  32'hFFFF_FFF4, 32'h0, 4'd3},
    '{K_RD,  5'd4,  32'h0, 32'h0000_0004, 4'd3},  // R3 only 3:1 kept
    '{K_WR,  5'd12, 32'hFFFF_FFFF, 32'h0, 4'd5},
    '{K_RD,  5'd12, 32'h0, 32'h0001_FFFF, 4'd5},  // R5 17-bit address
    '{K_WR,  5'd16, 32'hFFFF_FFFF, 32'h0, 4'd5},
    '{K_RD,  5'd16, 32'h0, 32'h0000_FFFF, 4'd5},  // R5 16-bit count
    '{K_WR,  5'd20, 32'hFFFF_FFFF, 32'h0, 4'd5},
    '{K_RD,  5'd20, 32'h0, 32'hFFC0_0000, 4'd5},  // R5 diagnostic field
    '{K_WR,  5'd0,  32'hFFFF_FFFF, 32'h0, 4'd4},
    '{K_RD,  5'd0,  32'h0, 32'h0000_0020, 4'd4},  // R4 power flags W1C
    '{K_EV,  5'd0,  EV_START, 32'h0, 4'd7},
    '{K_RD,  5'd8,  32'h0, 32'h8000_0000, 4'd7},  // R7 busy set
    '{K_WR,  5'd12, 32'h0, 32'h0, 4'd6},
    '{K_RD,  5'd12, 32'h0, 32'h0001_FFFF, 4'd6},  // R6 write refused
    '{K_RD,  5'd8,  32'h0, 32'h8008_0000, 4'd6},  // R6 programming error
    '{K_EV,  5'd0,  EV_ASET, 32'h0, 4'd9},
    '{K_RD,  5'd8,  32'h0, 32'h8009_0000, 4'd9},  // R9 attention set
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0000, 4'd12}, // R12 held back
    '{K_EV,  5'd0,  EV_DONE, 32'h0, 4'd8},
    '{K_RD,  5'd8,  32'h0, 32'h0009_2000, 4'd8},  // R8 done clears busy
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0001, 4'd11}, // R11 raised after busy ends
    '{K_WR,  5'd8,  32'hFFFF_FFFF, 32'h0, 4'd10},
    '{K_RD,  5'd8,  32'h0, 32'h0001_0000, 4'd10}, // R10 W1C leaves attention
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0001, 4'd13}, // R13 attention still holds
    '{K_EV,  5'd0,  EV_ACLR, 32'h0, 4'd9},
    '{K_RD,  5'd8,  32'h0, 32'h0000_0000, 4'd9},  // R9 attention cleared
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0000, 4'd13}, // R13 drop with no cause
    '{K_EV,  5'd0,  EV_START, 32'h0, 4'd8},
    '{K_WR,  5'd4,  32'h0000_0006, 32'h0, 4'd8},
    '{K_RD,  5'd8,  32'h0, 32'h0000_3000, 4'd8},  // R8 host abort
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0001, 4'd8},  // R8 abort interrupts
    '{K_RD,  5'd4,  32'h0, 32'h0000_0006, 4'd3},  // R3 abort bit stored
    '{K_WR,  5'd8,  32'h0000_3000, 32'h0, 4'd13},
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0000, 4'd13}, // R13 cleared by W1C
    '{K_WR,  5'd4,  32'h0, 32'h0, 4'd9},
    '{K_EV,  5'd0,  EV_EXC, 32'h0, 4'd9},
    '{K_RD,  5'd8,  32'h0, 32'h0000_0080, 4'd9},  // R9 exception
    '{K_WR,  5'd8,  32'h0000_0080, 32'h0, 4'd10},
    '{K_RD,  5'd8,  32'h0, 32'h0000_0000, 4'd10}, // R10 W1C
    '{K_EV,  5'd0,  EV_START, 32'h0, 4'd7},
    '{K_EV,  5'd0,  EV_START, 32'h0, 4'd7},
    '{K_RD,  5'd8,  32'h0, 32'h8008_0000, 4'd7},  // R7 restart error
    '{K_EV,  5'd0,  EV_FAULT, 32'h0, 4'd8},
    '{K_RD,  5'd8,  32'h0, 32'h0008_3000, 4'd8},  // R8 fault aborts
    '{K_IRQ, 5'd0,  32'h0, 32'h0000_0000, 4'd11}, // R11 disabled -> none
    '{K_WR,  5'd8,  32'hFFFF_FFFF, 32'h0, 4'd10},
    '{K_RD,  5'd24, 32'h0, 32'hA5A5_0F0F, 4'd10}, // R10 selected map
    '{K_WR,  5'd24, 32'h0, 32'h0, 4'd10},
    '{K_RD,  5'd24, 32'h0, 32'hA5A5_0F0F, 4'd10}, // R10 read-only
    '{K_RD,  5'd28, 32'h0, 32'h1234_5678, 4'd10}  // R10 command
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input int rq);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %08h expected %08h", rq, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d; host_size = sz;
    @(posedge clk); #1;
    host_req = 1'b0; host_we = 1'b0; host_size = SZ_LONG;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input int rq);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a; host_size = SZ_LONG;
    #1 check(host_rdata, exp, rq);
    host_req = 1'b0;
  endtask

  task automatic ev(input logic [31:0] m);
    @(negedge clk);
    xfer_start = m[0]; xfer_done = m[1]; xfer_fault = m[2];
    attn_set = m[3]; attn_clr = m[4]; exc_event = m[5];
    @(posedge clk); #1;
    {xfer_start, xfer_done, xfer_fault, attn_set, attn_clr, exc_event} = '0;
  endtask

  task automatic irq_chk(input logic exp, input int rq);
    @(negedge clk); #1;
    check({31'h0, irq}, {31'h0, exp}, rq);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end (all requirements), got hang expected finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      case (TBL[i].kind)
        K_WR:    wr(TBL[i].addr, TBL[i].data, SZ_LONG);
        K_RD:    rd(TBL[i].addr, TBL[i].exp, int'(TBL[i].rq));
        K_EV:    ev(TBL[i].data);
        default: irq_chk(TBL[i].exp[0], int'(TBL[i].rq));
      endcase
    end

    // R2: misaligned longword write
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 5'd13; host_wdata = 32'h0; host_size = SZ_LONG;
    #1 check({31'h0, host_err}, 32'h1, 2); // R2 flag
    @(posedge clk); #1; host_req = 1'b0; host_we = 1'b0;
    rd(5'd12, 32'h0001_FFFF, 2);           // R2 no effect
    // R2: word-sized write
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = 5'd12; host_wdata = 32'h0; host_size = 2'b01;
    #1 check({31'h0, host_err}, 32'h1, 2); // R2 flag
    @(posedge clk); #1; host_req = 1'b0; host_we = 1'b0; host_size = SZ_LONG;
    rd(5'd12, 32'h0001_FFFF, 2);           // R2 no effect
    // R2: misaligned read returns zero
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = 5'd10;
    #1 check(host_rdata, 32'h0, 2);        // R2 data zero
    check({31'h0, host_err}, 32'h1, 2);
    host_req = 1'b0;

    // R13: disabling interrupts drops the request
    wr(5'd4, 32'h4, SZ_LONG);
    ev(EV_DONE);
    irq_chk(1'b1, 11);                     // R11 done while idle
    wr(5'd4, 32'h0, SZ_LONG);
    irq_chk(1'b0, 13);                     // R13 enable cleared

    // R3: init returns adapter to reset state, keeps bits 3:1 of write
    ev(EV_START);
    wr(5'd4, 32'h0000_0005, SZ_LONG);
    rd(5'd8,  32'h0000_0000, 3);           // R3 status
    rd(5'd12, 32'h0000_0000, 3);           // R3 address
    rd(5'd16, 32'h0000_0000, 3);           // R3 count
    rd(5'd20, 32'h0000_0000, 3);           // R3 diagnostic
    rd(5'd0,  32'h0040_0020, 3);           // R3 config
    rd(5'd4,  32'h0000_0004, 3);           // R3 init self-clears
    irq_chk(1'b0, 3);

    summary();
  end
endmodule